// File: doc/BRIEF.md
# Constant 0.707 Complex Multiplier

This block scales a complex sample by a fixed factor of about 0.707, which is √2/2. It is used inside the butterfly stages of a 16-point FFT. The coefficient is 181/256 (0.70703125). It is formed from shifted copies of the input that are added together, so no general multiplier is used. In the same pass the product can also be rotated by −j, so a twiddle factor such as e^(−jπ/4) or its −j companion costs no extra stage.

Each sample that enters carries a multiply strobe and a rotate flag. A sample without the strobe passes through unchanged and keeps its place in the stream, so the surrounding FFT sees one fixed latency for every sample. A single stall input holds every register when it is low.

The result is not rounded: the scaled value is the arithmetic (floor) right shift of the exact integer product. Input and output have the same width.

Top module: `cm7_mul`

## Requirements
- R1: When the sample is marked for multiplication and the rotate flag is low, each output part equals floor(x·181/256) of the matching input part, taken as a two's-complement integer.
- R2: When the sample is marked and the rotate flag is high, the output real part equals floor(im·181/256) and the output imaginary part equals −floor(re·181/256).
- R3: While the stall enable is low, no register advances: the data outputs and the output strobe keep their values, and nothing presented at the inputs is captured.
- R4: An unmarked sample comes out with both parts unchanged, and its rotate flag has no effect.
- R5: A sample appears at the outputs after exactly 4 enabled clocks. Its multiply strobe is delivered on the output strobe in the same cycle.
- R6: While the asynchronous active-low reset is asserted, both data outputs and the output strobe are zero.
- R7: Full-scale inputs do not overflow. −2^(W−1) scales to −23168 and 2^(W−1)−1 scales to 23167 at W=16, and under rotation the negated value 23168 fits in the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Stall enable; low holds every register |
| sel_i | input | 1 | Multiply strobe for the sample on this cycle |
| rot_i | input | 1 | Rotate the product by −j (used only with sel_i) |
| re_i | input | W | Signed real part in |
| im_i | input | W | Signed imaginary part in |
| re_o | output | W | Signed real part out |
| im_o | output | W | Signed imaginary part out |
| sel_o | output | 1 | Multiply strobe of the sample now on the outputs |

## Verification
The assertions assume that the reset is released away from the clock edge and that the control inputs are never unknown once reset ends. They also assume the coefficient is below 2^FRAC, so the scaled magnitude can never exceed the input range. The stimulus drives every input half a cycle away from the active edge and holds it stable across that edge. It uses only the default coefficient, and it includes both full-scale extremes on purpose, with and without rotation. Stall cycles are scattered through the random phase so that the hold checks fire while samples are in flight.

// File: rtl/cm7_pkg.sv
`timescale 1ns/1ps
package cm7_pkg;
  typedef struct packed {
    logic sel;
    logic rot;
  } cm7_ctl_t;
endpackage

// File: rtl/cm7_lane.sv
`timescale 1ns/1ps
// One real-valued lane: shift-and-add scaling in two register stages.
module cm7_lane #(
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int COEF = 181
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] x_i,
  input  logic                sel_a_i,   // strobe aligned with stage-A registers
  output logic signed [W-1:0] y_o
);
  localparam int AW  = W + FRAC + 1;
  localparam int LOB = FRAC / 2;

  logic signed [AW-1:0] xe;
  logic signed [AW-1:0] lo_d, hi_d, lo_q, hi_q;
  logic signed [W-1:0]  raw_q;
  logic signed [AW-1:0] sum, sh;
  logic signed [W-1:0]  y_d;

  assign xe = {{(AW-W){x_i[W-1]}}, x_i};

  // partial sums: low coefficient bits and high coefficient bits
  always_comb begin
    lo_d = '0;
    hi_d = '0;
    for (int i = 0; i < FRAC; i++) begin
      if (COEF[i]) begin
        if (i < LOB) lo_d = lo_d + (xe <<< i);
        else         hi_d = hi_d + (xe <<< i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      raw_q <= '0;
    end else if (en) begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      raw_q <= x_i;
    end
  end

  always_comb begin
    sum = lo_q + hi_q;
    sh  = sum >>> FRAC;
    y_d = sel_a_i ? sh[W-1:0] : raw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  y_o <= '0;
    else if (en) y_o <= y_d;
  end

  // R1: a floor-scaled value keeps the sign of its source
  assert_sign_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en && sel_a_i |=> y_o[W-1] == $past(raw_q[W-1]));

  // R7: the shifted sum always fits the output word
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_a_i |-> (sh[AW-1:W-1] == '0 || sh[AW-1:W-1] == '1));
endmodule

// File: rtl/cm7_rot.sv
`timescale 1ns/1ps
// Final stage: optional multiplication by -j, output registers.
module cm7_rot #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] re_i,
  input  logic signed [W-1:0] im_i,
  input  logic                sel_i,
  input  logic                rot_i,
  output logic signed [W-1:0] re_o,
  output logic signed [W-1:0] im_o,
  output logic                sel_o
);
  logic signed [W-1:0] re_d, im_d;
  logic                turn;

  always_comb begin
    turn = sel_i & rot_i;
    re_d = turn ? im_i : re_i;
    im_d = turn ? -re_i : im_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_o  <= '0;
      im_o  <= '0;
      sel_o <= 1'b0;
    end else if (en) begin
      re_o  <= re_d;
      im_o  <= im_d;
      sel_o <= sel_i;
    end
  end

  // R2: rotation swaps the parts and negates the new imaginary part
  assert_rotate_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en && sel_i && rot_i |=> re_o == $past(im_i) && im_o == -$past(re_i));

  // R4: without the strobe the rotate flag is ignored
  assert_unmarked_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en && !sel_i |=> re_o == $past(re_i) && im_o == $past(im_i));

  // R3: a stall holds the outputs
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(re_o) && $stable(im_o) && $stable(sel_o));
endmodule

// File: rtl/cm7_mul.sv
`timescale 1ns/1ps
module cm7_mul #(
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int COEF = 181
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                sel_i,
  input  logic                rot_i,
  input  logic signed [W-1:0] re_i,
  input  logic signed [W-1:0] im_i,
  output logic signed [W-1:0] re_o,
  output logic signed [W-1:0] im_o,
  output logic                sel_o
);
  import cm7_pkg::*;

  localparam int NLANE = 2;

  logic signed [W-1:0] in_q  [NLANE];
  logic signed [W-1:0] lane_y[NLANE];
  logic signed [W-1:0] in_d  [NLANE];
  cm7_ctl_t c1_q, c2_q, c3_q, c_d;

  always_comb begin
    in_d[0] = re_i;
    in_d[1] = im_i;
    c_d.sel = sel_i;
    c_d.rot = rot_i;
  end

  // input stage and control pipe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NLANE; k++) in_q[k] <= '0;
      c1_q <= '0;
      c2_q <= '0;
      c3_q <= '0;
    end else if (en_i) begin
      for (int k = 0; k < NLANE; k++) in_q[k] <= in_d[k];
      c1_q <= c_d;
      c2_q <= c1_q;
      c3_q <= c2_q;
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    cm7_lane #(.W(W), .FRAC(FRAC), .COEF(COEF)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_i),
      .x_i     (in_q[g]),
      .sel_a_i (c2_q.sel),
      .y_o     (lane_y[g])
    );
  end

  cm7_rot #(.W(W)) u_rot (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_i),
    .re_i  (lane_y[0]),
    .im_i  (lane_y[1]),
    .sel_i (c3_q.sel),
    .rot_i (c3_q.rot),
    .re_o  (re_o),
    .im_o  (im_o),
    .sel_o (sel_o)
  );
endmodule

// File: tb/tb_cm7_mul.sv
`timescale 1ns/1ps
module tb_cm7_mul;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n, en_i, sel_i, rot_i;
  logic signed [W-1:0] re_i, im_i, re_o, im_o;
  logic sel_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  cm7_mul dut (.clk(clk), .rst_n(rst_n), .en_i(en_i), .sel_i(sel_i), .rot_i(rot_i),
               .re_i(re_i), .im_i(im_i), .re_o(re_o), .im_o(im_o), .sel_o(sel_o));

  typedef struct {
    int    re;
    int    im;
    bit    sel;
    string tag;
  } exp_t;

  exp_t pipe[4];
  bit   last_en = 1;

  function automatic int scl(int x);
    return (x * 181) >>> 8;
  endfunction

  function automatic exp_t model(int re, int im, bit s, bit r);
    exp_t e;
    e.sel = s;
    if (!s) begin
      e.re = re; e.im = im; e.tag = "R4";
    end else if (r) begin
      e.re = scl(im); e.im = -scl(re); e.tag = "R2";
    end else begin
      e.re = scl(re); e.im = scl(im); e.tag = "R1";
    end
    if (s && (re == -32768 || re == 32767 || im == -32768 || im == 32767)) e.tag = "R7";
    return e;
  endfunction

  // behavioural reference: four enabled stages of delay
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) pipe[k] = '{0, 0, 1'b0, "R6"};
      last_en = 1;
    end else begin
      last_en = en_i;
      if (en_i) begin
        for (int k = 3; k > 0; k--) pipe[k] = pipe[k-1];
        pipe[0] = model(int'(re_i), int'(im_i), sel_i, rot_i);
      end
    end
  end

  // compare every cycle, half a period after the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tg;
      tg = last_en ? pipe[3].tag : "R3";
      n_vec++;
      if (int'(re_o) != pipe[3].re || int'(im_o) != pipe[3].im) begin
        n_bad++;
        $display("FAIL %s data: got (%0d,%0d) expected (%0d,%0d) at cycle %0d",
                 tg, re_o, im_o, pipe[3].re, pipe[3].im, cyc);
      end
      if (sel_o != pipe[3].sel) begin
        n_bad++;
        $display("FAIL %s R5 strobe: got %0b expected %0b at cycle %0d",
                 tg, sel_o, pipe[3].sel, cyc);
      end
    end
  end

  task automatic drive(int re, int im, bit s, bit r, bit e);
    @(negedge clk);
    #1;
    re_i = W'(re); im_i = W'(im); sel_i = s; rot_i = r; en_i = e;
  endtask

  initial begin : wd
    while (cyc < 150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int ext[7] = '{-32768, 32767, -1, 1, 0, 256, -256};
    rst_n = 0; en_i = 0; sel_i = 0; rot_i = 0; re_i = 0; im_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R6: outputs cleared while reset is held
    n_vec++;
    if (re_o !== 0 || im_o !== 0 || sel_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R6 reset: got (%0d,%0d,%0b) expected (0,0,0)", re_o, im_o, sel_o);
    end
    #1 rst_n = 1;

    // R7 / R1 / R2: extremes, plain and rotated
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++) begin
        drive(ext[a], ext[b], 1, 0, 1);
        drive(ext[a], ext[b], 1, 1, 1);
      end
    // R4: unmarked samples with the rotate flag set
    for (int a = 0; a < 7; a++) drive(ext[a], ext[6-a], 0, 1, 1);
    // R5: single strobe with a stall in flight
    drive(1000, -1000, 1, 0, 1);
    drive(0, 0, 0, 0, 1);
    drive(555, 555, 1, 1, 0);   // R3: ignored while stalled
    drive(0, 0, 0, 0, 0);
    repeat (6) drive(0, 0, 0, 0, 1);

    // random mix with scattered stalls
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a, b;
      logic [3:0]  k;
      a = 16'($urandom);
      b = 16'($urandom);
      k = 4'($urandom);
      drive(int'($signed(a)), int'($signed(b)), k[0] | k[1], k[2], k[3] | k[1] | k[0]);
    end
    repeat (8) drive(0, 0, 0, 0, 1);
    @(negedge clk);
    #1 done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule